// File: doc/BRIEF.md
# Dual-Mode Converter Input Latch Interface

This block is the digital front end of a 14-bit converter. A data word reaches an input latch by one of two routes. The parallel route takes the whole 14-bit bus under an active-low select and an active-low write strobe. The serial route reuses some of the same pins as a frame-sync, serial-clock and serial-data port. In that mode, two more bus pins choose the bit order and the position of the 14 valid bits within a 16-slot frame. A separate active-low load strobe copies the input latch into the output latch, and the output latch drives the converter code.

All pins are sampled on the rising edge of the system clock. The edges of the strobes, the frame sync and the serial clock are detected by comparing each sample with the one before it. The mode-select input takes the place of tying the select pin to a special level. Reset clears both latches. The load-edge detector comes out of reset so that a load pin already held low does not copy anything into the output latch.

Top module: `dml_dac_front`

## Requirements
- R1: While reset is asserted and after it is released, the input and output latches hold 0, so code_out reads 0 until a load occurs.
- R2: With ser_mode=0, at each clock edge where cs_n=0 and wr_n=0 are sampled, the input latch takes data_pins[13:0]. At any other edge with ser_mode=0, the input latch is unchanged.
- R3: With ser_mode=1, the port pins are: wr_n is the active-low frame sync, data_pins[13] is serial data and data_pins[12] is the serial clock. A frame starts at an edge where wr_n is sampled low after a high sample. A slot is taken at each later edge where data_pins[12] is sampled low after a high sample while wr_n was low in both samples. In this mode the cs_n/wr_n parallel write never occurs.
- R4: data_pins[11] sampled at the frame start sets the bit order. A 1 sends the MSB (bit 13) first and a 0 sends the LSB (bit 0) first.
- R5: data_pins[10] sampled at the frame start sets the justification. A 1 (left) makes slots 0 to 13 valid and slots 14 and 15 ignored. A 0 (right) ignores slots 0 and 1 and makes slots 2 to 15 valid.
- R6: The input latch takes the assembled word at the clock edge that takes slot 15. Serial clock edges after slot 15 are ignored until a new frame start.
- R7: Changes on data_pins[11] and data_pins[10] after the frame start have no effect on that frame.
- R8: The frame is discarded and the input latch keeps its value in either case: wr_n rises before slot 15 is taken, or ser_mode drops to 0 during the frame.
- R9: At a clock edge where ld_n is sampled low after a high sample, the output latch takes the value the input latch held before that edge. At all other edges code_out is unchanged.
- R10: After reset, a load needs a high sample of ld_n followed by a low sample. An ld_n held low through reset release loads nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode | input | 1 | 1 selects the serial route, 0 the parallel route |
| cs_n | input | 1 | Active-low select for parallel writes |
| wr_n | input | 1 | Parallel write strobe; active-low frame sync in serial mode |
| data_pins | input | 14 | Parallel word; in serial mode [13] data, [12] clock, [11] order, [10] justification |
| ld_n | input | 1 | Active-low load strobe, acts on its falling edge |
| code_out | output | 14 | Output latch contents, the converter code |

## Verification
Four things are checked on every cycle: the output latch moves only on a sampled load edge and then takes the earlier input-latch value; a parallel write copies the bus; the input latch stays put outside a parallel write in parallel mode; and it stays put while frame sync is high in serial mode. Only the bench scenarios show the following: that a complete frame assembles the right word for all four order and justification settings, that the order and justification pins are frozen at the frame start, that aborted frames and extra clock edges are ignored, and that a load pin held low through reset does nothing. A behavioural model in the bench, built on a slot queue, also compares code_out on every cycle.

// File: rtl/dml_pkg.sv
package dml_pkg;
    localparam int unsigned WORD_W      = 14;
    localparam int unsigned FRAME_SLOTS = 16;

    typedef enum logic {
        ORDER_LSB_FIRST = 1'b0,
        ORDER_MSB_FIRST = 1'b1
    } bit_order_e;

    typedef enum logic {
        JUST_RIGHT = 1'b0,
        JUST_LEFT  = 1'b1
    } justify_e;
endpackage

// File: rtl/dml_serial_rx.sv
module dml_serial_rx
    import dml_pkg::*;
#(
    parameter int unsigned WORD_W      = dml_pkg::WORD_W,
    parameter int unsigned FRAME_SLOTS = dml_pkg::FRAME_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fsync_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              order_pin,
    input  logic              just_pin,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word
);
    localparam int unsigned CNT_W = $clog2(FRAME_SLOTS);
    localparam int unsigned PAD   = FRAME_SLOTS - WORD_W;
    localparam int unsigned LAST  = FRAME_SLOTS - 1;

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  slot;
        logic [WORD_W-1:0] acc;
        bit_order_e        order;
        justify_e          just;
        logic              fs_prev;
        logic              sck_prev;
    } rx_state_t;

    rx_state_t s_d, s_q;

    logic              frame_fall;
    logic              bit_edge;
    logic              in_window;
    logic [WORD_W-1:0] acc_next;

    always_comb begin
        s_d         = s_q;
        commit      = 1'b0;
        commit_word = s_q.acc;
        acc_next    = s_q.acc;
        in_window   = 1'b0;

        frame_fall = s_q.fs_prev & ~fsync_n;
        bit_edge   = s_q.active & s_q.sck_prev & ~sclk & ~fsync_n & ~s_q.fs_prev;

        s_d.fs_prev  = fsync_n;
        s_d.sck_prev = sclk;

        if (!enable) begin
            s_d.active = 1'b0;
        end else if (fsync_n) begin
            s_d.active = 1'b0;
        end else if (frame_fall) begin
            s_d.active = 1'b1;
            s_d.slot   = '0;
            s_d.acc    = '0;
            s_d.order  = bit_order_e'(order_pin);
            s_d.just   = justify_e'(just_pin);
        end else if (bit_edge) begin
            if (s_q.just == JUST_LEFT) begin
                in_window = (int'(s_q.slot) < int'(WORD_W));
            end else begin
                in_window = (int'(s_q.slot) >= int'(PAD));
            end
            if (in_window) begin
                if (s_q.order == ORDER_MSB_FIRST) begin
                    acc_next = {s_q.acc[WORD_W-2:0], sdata};
                end else begin
                    acc_next = {sdata, s_q.acc[WORD_W-1:1]};
                end
            end
            s_d.acc = acc_next;
            if (int'(s_q.slot) == int'(LAST)) begin
                commit      = 1'b1;
                commit_word = acc_next;
                s_d.active  = 1'b0;
            end else begin
                s_d.slot = s_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.active   <= 1'b0;
            s_q.slot     <= '0;
            s_q.acc      <= '0;
            s_q.order    <= ORDER_MSB_FIRST;
            s_q.just     <= JUST_LEFT;
            s_q.fs_prev  <= 1'b0;
            s_q.sck_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/dml_latch_pair.sv
module dml_latch_pair #(
    parameter int unsigned WORD_W = dml_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_we,
    input  logic [WORD_W-1:0] par_word,
    input  logic              ser_we,
    input  logic [WORD_W-1:0] ser_word,
    input  logic              ld_n,
    output logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic [WORD_W-1:0] in_lat;
        logic [WORD_W-1:0] out_lat;
        logic              ld_prev;
    } lat_state_t;

    lat_state_t l_d, l_q;

    always_comb begin
        l_d         = l_q;
        l_d.ld_prev = ld_n;
        if (par_we) begin
            l_d.in_lat = par_word;
        end else if (ser_we) begin
            l_d.in_lat = ser_word;
        end
        if (l_q.ld_prev && !ld_n) begin
            l_d.out_lat = l_q.in_lat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q.in_lat  <= '0;
            l_q.out_lat <= '0;
            l_q.ld_prev <= 1'b0;
        end else begin
            l_q <= l_d;
        end
    end

    assign in_word  = l_q.in_lat;
    assign out_word = l_q.out_lat;
endmodule

// File: rtl/dml_dac_front.sv
module dml_dac_front #(
    parameter int unsigned WORD_W      = dml_pkg::WORD_W,
    parameter int unsigned FRAME_SLOTS = dml_pkg::FRAME_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [WORD_W-1:0] data_pins,
    input  logic              ld_n,
    output logic [WORD_W-1:0] code_out
);
    localparam int unsigned SDATA_BIT = WORD_W - 1;
    localparam int unsigned SCLK_BIT  = WORD_W - 2;
    localparam int unsigned ORDER_BIT = WORD_W - 3;
    localparam int unsigned JUST_BIT  = WORD_W - 4;

    logic              par_we;
    logic              ser_we;
    logic [WORD_W-1:0] ser_word;
    logic [WORD_W-1:0] in_word;

    assign par_we = ~ser_mode & ~cs_n & ~wr_n;

    dml_serial_rx #(
        .WORD_W      (WORD_W),
        .FRAME_SLOTS (FRAME_SLOTS)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ser_mode),
        .fsync_n     (wr_n),
        .sclk        (data_pins[SCLK_BIT]),
        .sdata       (data_pins[SDATA_BIT]),
        .order_pin   (data_pins[ORDER_BIT]),
        .just_pin    (data_pins[JUST_BIT]),
        .commit      (ser_we),
        .commit_word (ser_word)
    );

    dml_latch_pair #(
        .WORD_W (WORD_W)
    ) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_we   (par_we),
        .par_word (data_pins),
        .ser_we   (ser_we),
        .ser_word (ser_word),
        .ld_n     (ld_n),
        .in_word  (in_word),
        .out_word (code_out)
    );
endmodule

// File: rtl/dml_dac_front_chk.sv
module dml_dac_front_chk #(
    parameter int unsigned WORD_W = dml_pkg::WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_mode,
    input logic              cs_n,
    input logic              wr_n,
    input logic [WORD_W-1:0] data_pins,
    input logic              ld_n,
    input logic [WORD_W-1:0] in_word,
    input logic [WORD_W-1:0] code_out
);
    logic ld_seen_high;

    always_ff @(posedge clk) begin
        if (!rst_n) ld_seen_high <= 1'b0;
        else        ld_seen_high <= ld_n;
    end

    // R1: latches are cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (code_out == '0 && in_word == '0));

    // R9: a load edge copies the earlier input latch value
    a_r9_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_seen_high && !ld_n) |=> (code_out == $past(in_word)));

    // R9 / R10: without a sampled high-then-low load, the output holds
    a_r10_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_seen_high && !ld_n) |=> $stable(code_out));

    // R2: a parallel write takes the bus
    a_r2_par_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && !cs_n && !wr_n) |=> (in_word == $past(data_pins)));

    // R2: no write strobe in parallel mode leaves the input latch alone
    a_r2_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && (cs_n || wr_n)) |=> $stable(in_word));

    // R8: with frame sync high in serial mode nothing is written
    a_r8_sync_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && wr_n) |=> $stable(in_word));
endmodule

bind dml_dac_front dml_dac_front_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_mode  (ser_mode),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .data_pins (data_pins),
    .ld_n      (ld_n),
    .in_word   (in_word),
    .code_out  (code_out)
);

// File: tb/test_dml_dac_front.sv
`timescale 1ns/1ps
module test_dml_dac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [13:0] pins = '0;
    logic        ld_n = 1'b1;
    logic [13:0] code_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dml_dac_front i_dml_dac_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_mode  (ser_mode),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .data_pins (pins),
        .ld_n      (ld_n),
        .code_out  (code_out)
    );

    // Behavioural reference: slots collected in a queue, word built at the end
    logic [13:0] m_in, m_out;
    logic        m_ldp, m_fsp, m_sckp, m_busy, m_msb, m_left;
    logic        slots[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_in = '0; m_out = '0; m_ldp = 1'b0; m_fsp = 1'b0; m_sckp = 1'b0;
            m_busy = 1'b0; slots.delete();
        end else begin
            if (m_ldp && !ld_n) m_out = m_in;
            m_ldp = ld_n;
            if (!ser_mode) begin
                m_busy = 1'b0;
                if (!cs_n && !wr_n) m_in = pins;
            end else if (wr_n) begin
                m_busy = 1'b0;
            end else if (m_fsp) begin
                m_busy = 1'b1; slots.delete();
                m_msb = pins[11]; m_left = pins[10];
            end else if (m_busy && m_sckp && !pins[12]) begin
                slots.push_back(pins[13]);
                if (slots.size() == 16) begin
                    for (int v = 0; v < 14; v++)
                        m_in[m_msb ? 13 - v : v] = slots[m_left ? v : v + 2];
                    m_busy = 1'b0;
                end
            end
            m_fsp = wr_n; m_sckp = pins[12];
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (code_out !== m_out) begin
                errors++;
                $display("FAIL R9 model compare: actual %h expected %h", code_out, m_out);
            end
        end
    end

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic par_write(input logic [13:0] w, input logic sel_n);
        @(negedge clk); pins = w; cs_n = sel_n; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic load_pulse();
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk); ld_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic slot_bit(input logic [13:0] w, input logic msb,
                                      input logic left, input int s);
        int v = left ? s : s - 2;
        if (v < 0 || v > 13) return 1'b1;
        return msb ? w[13 - v] : w[v];
    endfunction

    task automatic send_frame(input logic [13:0] w, input logic msb, input logic left,
                              input int nslots, input logic flip_mid);
        @(negedge clk); pins = '0; pins[12] = 1'b1; pins[11] = msb; pins[10] = left; wr_n = 1'b1;
        @(negedge clk); wr_n = 1'b0;
        for (int s = 0; s < nslots; s++) begin
            @(negedge clk); pins[12] = 1'b1; pins[13] = slot_bit(w, msb, left, s);
            if (flip_mid) begin pins[11] = ~msb; pins[10] = ~left; end
            @(negedge clk); pins[12] = 1'b0;
        end
        @(negedge clk); wr_n = 1'b1; pins[12] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset output", code_out, 14'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", code_out, 14'h0000);

        par_write(14'h2A5C, 1'b0);
        @(negedge clk);
        check("R9 no load yet", code_out, 14'h0000);
        load_pulse();
        check("R2 parallel load", code_out, 14'h2A5C);
        par_write(14'h1111, 1'b1);
        load_pulse();
        check("R2 cs_n high ignored", code_out, 14'h2A5C);

        ser_mode = 1'b1;
        send_frame(14'h3C96, 1'b1, 1'b1, 18, 1'b0);
        check("R6 serial not yet loaded", code_out, 14'h2A5C);
        load_pulse();
        check("R3 R4 msb-first left", code_out, 14'h3C96);
        send_frame(14'h0F3A, 1'b0, 1'b1, 16, 1'b0);
        load_pulse();
        check("R4 lsb-first left", code_out, 14'h0F3A);
        send_frame(14'h2471, 1'b1, 1'b0, 17, 1'b0);
        load_pulse();
        check("R5 msb-first right", code_out, 14'h2471);
        send_frame(14'h1BE5, 1'b0, 1'b0, 16, 1'b0);
        load_pulse();
        check("R5 lsb-first right", code_out, 14'h1BE5);
        send_frame(14'h05D3, 1'b1, 1'b0, 16, 1'b1);
        load_pulse();
        check("R7 pins frozen at start", code_out, 14'h05D3);
        send_frame(14'h3FFF, 1'b1, 1'b1, 15, 1'b0);
        load_pulse();
        check("R8 short frame dropped", code_out, 14'h05D3);

        fork
            send_frame(14'h1234, 1'b1, 1'b1, 16, 1'b0);
            begin repeat (12) @(negedge clk); ser_mode = 1'b0; end
        join
        ser_mode = 1'b1;
        load_pulse();
        check("R8 mode drop aborts", code_out, 14'h05D3);

        ser_mode = 1'b0;
        par_write(14'h0777, 1'b0);
        load_pulse();
        check("R2 back to parallel", code_out, 14'h0777);

        @(negedge clk); ld_n = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset clears output", code_out, 14'h0000);
        rst_n = 1'b1;
        par_write(14'h1ABC, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 held-low load ignored", code_out, 14'h0000);
        ld_n = 1'b1;
        load_pulse();
        check("R10 load after high", code_out, 14'h1ABC);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule